// File: doc/BRIEF.md
# Codec Serial Link Frame Receiver

This block sits on the codec side of a five-wire audio link. It receives the stream that the controller sends to the codec and finds the start of each frame from a rising frame strobe. It captures the tag slot and the first four data slots bit by bit, and acts on them once the fourth slot has arrived. A register access in slots 1 and 2 writes to or reads from a bank of 16-bit control registers that sits at even indices only. The left and right playback samples in slots 3 and 4 are rounded from 20 to 17 bits and presented to the converters with a one-cycle valid strobe.

The block runs on a single system clock. An enable input, `smp_en`, marks each cycle that stands for a falling bit-clock edge, and the strobe and data are sampled only in those cycles. A read command is not answered here. Its index and the current register contents go out on `rd_req_o`, `rd_idx_o` and `rd_data_o` to the transmitter, which returns them in the next frame. The six low bits of the register at index 26h drive the powerdown outputs. Registers keep their contents for as long as `smp_en` stays low.

Top module: `lrx_top`

## Requirements
- R1: A frame starts in an enabled cycle where `sync_i` is 1 and the strobe value sampled in the previous enabled cycle was 0. The next enabled cycle samples tag bit 15. Bits then arrive MSB first: 16 tag bits, followed by slots 1 to 4 of 20 bits each. A new strobe rise restarts capture, even in the middle of a frame.
- R2: In cycles where `smp_en` is 0, neither `sync_i` nor `sdo_i` is sampled, and no capture state advances.
- R3: When tag bit 15 (frame valid) is 0, the frame causes no register write, no read request and no sample strobe.
- R4: A write happens when tag bits 15, 14 and 13 are all set, slot 1 bit 19 is 0 and the index in slot 1 bits 18..12 is even. The write stores slot 2 bits 19..4 in that register. If tag bit 13 is clear, nothing is written.
- R5: Writes to odd indices are ignored. A read of an odd index returns 0.
- R6: A read command (tag bits 15 and 14 set, slot 1 bit 19 = 1) pulses `rd_req_o` for exactly one cycle. In that cycle `rd_idx_o` holds slot 1 bits 18..12 and `rd_data_o` holds the register value from before the frame.
- R7: When tag bits 15 and 12 are set, the rounded slot 3 value is loaded into `pcm_l_o` and `pcm_l_vld_o` pulses for one cycle. Tag bits 15 and 11 do the same for slot 4, `pcm_r_o` and `pcm_r_vld_o`. The sample outputs change at no other time.
- R8: Rounding treats the 20-bit slot as two's complement, adds 4 and shifts right arithmetically by 3, which rounds halves upward. A positive result above 0FFFFh saturates to 0FFFFh.
- R9: `pwr_ctl_o` equals bits 5..0 of the register at index 26h and changes only when that register is written.
- R10: After reset, all registers, both sample outputs, all strobes and `pwr_ctl_o` are 0.
- R11: Tag bits 10..0 have no effect on the frame's result.
- R12: The top even index, 7Eh, is writable and readable like every other even index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Marks a cycle that stands for a falling bit-clock edge |
| sync_i | input | 1 | Frame strobe |
| sdo_i | input | 1 | Serial data from the controller |
| pcm_l_o | output | 17 | Rounded left playback sample |
| pcm_l_vld_o | output | 1 | One-cycle strobe for a new left sample |
| pcm_r_o | output | 17 | Rounded right playback sample |
| pcm_r_vld_o | output | 1 | One-cycle strobe for a new right sample |
| rd_req_o | output | 1 | One-cycle read request for the transmitter |
| rd_idx_o | output | 7 | Register index that was read |
| rd_data_o | output | 16 | Data at that index (0 for odd indices) |
| pwr_ctl_o | output | 6 | Powerdown controls from register 26h |

## Verification
The hardest case to reach from the ports is a frame that is abandoned partway. The strobe rises again before slot 4 has finished, and the block must throw away the partial capture without committing anything. The stimulus covers this by sending a truncated frame that carries a valid write tag, then at once sending a full frame, and checking that only the second one takes effect. A second hard case is a frame spread out by idle enable cycles in which the data line carries the inverted bit. This checks that only the enabled cycles count.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  localparam int SLOT_W   = 20;    // bits per data slot
  localparam int TAG_W    = 16;    // bits in the tag slot
  localparam int NSLOT    = 4;     // data slots captured
  localparam int DATA_W   = 16;    // control register width
  localparam int IDX_W    = 7;     // register index width
  localparam int PCM_W    = 17;    // converter resolution
  localparam int NUM_REGS = 64;    // even-indexed registers
  localparam int PWR_IDX  = 'h26;  // powerdown register index
  localparam int PWR_W    = 6;     // powerdown control bits
endpackage

// File: rtl/lrx_deframer.sv
module lrx_deframer #(
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int NSLOT  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             smp_en,
  input  logic                             sync_i,
  input  logic                             sdo_i,
  output logic [NSLOT:0]                   tagv_o,
  output logic [NSLOT-1:0][SLOT_W-1:0]     slots_o,
  output logic                             done_o
);
  localparam int TOTAL = TAG_W + NSLOT * SLOT_W;
  localparam int CNT_W = $clog2(TOTAL);

  logic                         sync_q, sync_d;
  logic                         act_q, act_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic [SLOT_W-2:0]            sh_q, sh_d;
  logic [SLOT_W-1:0]            sh_nx;
  logic [NSLOT:0]               tagv_q, tagv_d;
  logic [NSLOT-1:0][SLOT_W-1:0] slots_q, slots_d;
  logic                         done_q, done_d;

  assign sh_nx = {sh_q, sdo_i};

  // next-state
  always_comb begin
    sync_d  = sync_q;
    act_d   = act_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tagv_d  = tagv_q;
    slots_d = slots_q;
    done_d  = 1'b0;
    if (smp_en) begin
      sync_d = sync_i;
      if (sync_i && !sync_q) begin
        act_d = 1'b1;
        cnt_d = '0;
      end else if (act_q) begin
        sh_d  = sh_nx[SLOT_W-2:0];
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(TAG_W - 1))
          tagv_d = sh_nx[TAG_W-1 -: NSLOT+1];
        for (int s = 0; s < NSLOT; s++) begin
          if (cnt_q == CNT_W'(TAG_W + SLOT_W * (s + 1) - 1))
            slots_d[s] = sh_nx;
        end
        if (cnt_q == CNT_W'(TOTAL - 1)) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      tagv_q  <= '0;
      slots_q <= '0;
      done_q  <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      act_q   <= act_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tagv_q  <= tagv_d;
      slots_q <= slots_d;
      done_q  <= done_d;
    end
  end

  assign tagv_o  = tagv_q;
  assign slots_o = slots_q;
  assign done_o  = done_q;
endmodule

// File: rtl/lrx_round.sv
module lrx_round #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 17
) (
  input  logic [IN_W-1:0]  smp_i,
  output logic [OUT_W-1:0] smp_o
);
  localparam int DROP = IN_W - OUT_W;

  generate
    if (DROP == 0) begin : g_pass
      assign smp_o = smp_i;
    end else begin : g_rnd
      logic [IN_W:0]  sum;
      logic [OUT_W:0] res;
      logic           ovf;
      logic           unused_lsb;
      assign sum = {smp_i[IN_W-1], smp_i} + ((IN_W+1)'(1) << (DROP - 1));
      assign res = sum[IN_W:DROP];
      assign ovf = res[OUT_W] != res[OUT_W-1];
      assign unused_lsb = ^sum[DROP-1:0];
      // only positive values can overflow after adding half an LSB
      assign smp_o = ovf ? {1'b0, {(OUT_W-1){1'b1}}} : res[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/lrx_regbank.sv
module lrx_regbank #(
  parameter int NUM_REGS = 64,
  parameter int IDX_W    = 7,
  parameter int DATA_W   = 16,
  parameter int PWR_IDX  = 'h26,
  parameter int PWR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [PWR_W-1:0]  pwr_o
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              wr_hit, rd_hit;

  generate
    if (SEL_W + 1 < IDX_W) begin : g_hi
      assign wr_hit = wr_en && !wr_idx[0] && (wr_idx[IDX_W-1:SEL_W+1] == '0)
                      && (int'(wr_idx[SEL_W:1]) < NUM_REGS);
      assign rd_hit = !rd_idx[0] && (rd_idx[IDX_W-1:SEL_W+1] == '0)
                      && (int'(rd_idx[SEL_W:1]) < NUM_REGS);
    end else begin : g_full
      assign wr_hit = wr_en && !wr_idx[0] && (int'(wr_idx[SEL_W:1]) < NUM_REGS);
      assign rd_hit = !rd_idx[0] && (int'(rd_idx[SEL_W:1]) < NUM_REGS);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_hit) begin
      regs_q[wr_idx[SEL_W:1]] <= wr_data;
    end
  end

  assign rd_data = rd_hit ? regs_q[rd_idx[SEL_W:1]] : '0;
  assign pwr_o   = regs_q[PWR_IDX / 2][PWR_W-1:0];
endmodule

// File: rtl/lrx_top.sv
module lrx_top
  import lrx_pkg::*;
#(
  parameter int P_SLOT_W   = SLOT_W,
  parameter int P_TAG_W    = TAG_W,
  parameter int P_DATA_W   = DATA_W,
  parameter int P_IDX_W    = IDX_W,
  parameter int P_PCM_W    = PCM_W,
  parameter int P_NUM_REGS = NUM_REGS,
  parameter int P_PWR_W    = PWR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_en,
  input  logic                sync_i,
  input  logic                sdo_i,
  output logic [P_PCM_W-1:0]  pcm_l_o,
  output logic                pcm_l_vld_o,
  output logic [P_PCM_W-1:0]  pcm_r_o,
  output logic                pcm_r_vld_o,
  output logic                rd_req_o,
  output logic [P_IDX_W-1:0]  rd_idx_o,
  output logic [P_DATA_W-1:0] rd_data_o,
  output logic [P_PWR_W-1:0]  pwr_ctl_o
);
  localparam int NS      = NSLOT;
  localparam int NCH     = 2;
  localparam int CMD_BIT = P_SLOT_W - 1;
  localparam int IDX_LO  = CMD_BIT - P_IDX_W;

  logic [NS:0]                   tagv;
  logic [NS-1:0][P_SLOT_W-1:0]   slots;
  logic                          done;

  lrx_deframer #(.SLOT_W(P_SLOT_W), .TAG_W(P_TAG_W), .NSLOT(NS)) u_defr (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_i(sync_i), .sdo_i(sdo_i),
    .tagv_o(tagv), .slots_o(slots), .done_o(done)
  );

  // decode of tag and command slot
  logic                frm_ok, cmd_ok, dat_ok, is_rd, wr_en;
  logic [P_IDX_W-1:0]  cmd_idx;
  logic [P_DATA_W-1:0] wr_data, bank_rd;
  logic                unused_bits;

  assign frm_ok  = done && tagv[NS];
  assign cmd_ok  = frm_ok && tagv[NS-1];
  assign dat_ok  = tagv[NS-2];
  assign is_rd   = slots[0][CMD_BIT];
  assign cmd_idx = slots[0][CMD_BIT-1:IDX_LO];
  assign wr_data = slots[1][P_SLOT_W-1 -: P_DATA_W];
  assign wr_en   = cmd_ok && !is_rd && dat_ok && !cmd_idx[0];
  assign unused_bits = ^{slots[0][IDX_LO-1:0], slots[1][P_SLOT_W-P_DATA_W-1:0]};

  lrx_regbank #(
    .NUM_REGS(P_NUM_REGS), .IDX_W(P_IDX_W), .DATA_W(P_DATA_W),
    .PWR_IDX(PWR_IDX), .PWR_W(P_PWR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cmd_idx),
    .wr_data(wr_data), .rd_idx(cmd_idx), .rd_data(bank_rd), .pwr_o(pwr_ctl_o)
  );

  // read request toward the transmitter
  logic                rd_req_q, rd_req_d;
  logic [P_IDX_W-1:0]  rd_idx_q;
  logic [P_DATA_W-1:0] rd_data_q;

  assign rd_req_d = cmd_ok && is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req_q  <= 1'b0;
      rd_idx_q  <= '0;
      rd_data_q <= '0;
    end else begin
      rd_req_q <= rd_req_d;
      if (rd_req_d) begin
        rd_idx_q  <= cmd_idx;
        rd_data_q <= bank_rd;
      end
    end
  end

  assign rd_req_o  = rd_req_q;
  assign rd_idx_o  = rd_idx_q;
  assign rd_data_o = rd_data_q;

  // playback channels: slot 3 -> left, slot 4 -> right
  logic [NCH-1:0][P_PCM_W-1:0] pcm_q;
  logic [NCH-1:0]              pvld_q;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [P_PCM_W-1:0] rnd;
      logic               load;

      lrx_round #(.IN_W(P_SLOT_W), .OUT_W(P_PCM_W)) u_rnd (
        .smp_i(slots[2+ch]), .smp_o(rnd)
      );

      assign load = frm_ok && tagv[NS-3-ch];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pcm_q[ch]  <= '0;
          pvld_q[ch] <= 1'b0;
        end else begin
          pvld_q[ch] <= load;
          if (load) pcm_q[ch] <= rnd;
        end
      end
    end
  endgenerate

  assign pcm_l_o     = pcm_q[0];
  assign pcm_r_o     = pcm_q[1];
  assign pcm_l_vld_o = pvld_q[0];
  assign pcm_r_vld_o = pvld_q[1];
endmodule

// File: rtl/lrx_top_chk.sv
module lrx_top_chk #(
  parameter int PCM_W  = 17,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16,
  parameter int PWR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_ok,
  input logic              wr_en,
  input logic [PCM_W-1:0]  pcm_l_o,
  input logic              pcm_l_vld_o,
  input logic [PCM_W-1:0]  pcm_r_o,
  input logic              pcm_r_vld_o,
  input logic              rd_req_o,
  input logic [IDX_W-1:0]  rd_idx_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [PWR_W-1:0]  pwr_ctl_o
);
  // R7
  pcm_l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_l_o != $past(pcm_l_o)) |-> pcm_l_vld_o);
  // R7
  pcm_r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_r_o != $past(pcm_r_o)) |-> pcm_r_vld_o);
  // R3
  pcm_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_l_vld_o || pcm_r_vld_o || rd_req_o) |-> $past(frm_ok));
  // R6
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o);
  // R5
  odd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && rd_idx_o[0]) |-> (rd_data_o == '0));
  // R9
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pwr_ctl_o));
endmodule

bind lrx_top lrx_top_chk #(
  .PCM_W(P_PCM_W), .IDX_W(P_IDX_W), .DATA_W(P_DATA_W), .PWR_W(P_PWR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .frm_ok(frm_ok), .wr_en(wr_en),
  .pcm_l_o(pcm_l_o), .pcm_l_vld_o(pcm_l_vld_o),
  .pcm_r_o(pcm_r_o), .pcm_r_vld_o(pcm_r_vld_o),
  .rd_req_o(rd_req_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o),
  .pwr_ctl_o(pwr_ctl_o)
);

// File: tb/lrx_top_tb_top.sv
`timescale 1ns/1ps
module lrx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0;
  logic        sync_i = 1'b0;
  logic        sdo_i = 1'b0;
  logic [16:0] pcm_l_o, pcm_r_o;
  logic        pcm_l_vld_o, pcm_r_vld_o, rd_req_o;
  logic [6:0]  rd_idx_o;
  logic [15:0] rd_data_o;
  logic [5:0]  pwr_ctl_o;

  always #4 clk = ~clk;

  lrx_top dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sync_i(sync_i), .sdo_i(sdo_i),
    .pcm_l_o(pcm_l_o), .pcm_l_vld_o(pcm_l_vld_o),
    .pcm_r_o(pcm_r_o), .pcm_r_vld_o(pcm_r_vld_o),
    .rd_req_o(rd_req_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o),
    .pwr_ctl_o(pwr_ctl_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  logic [16:0] q_l[$];
  logic [16:0] q_r[$];
  logic [22:0] q_rd[$];   // {idx, data}
  logic [15:0] mdl [64];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] rnd17(input logic [19:0] s);
    int v;
    v = int'($signed(s));
    v = (v + 4) >>> 3;
    if (v > 65535) v = 65535;
    return v[16:0];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      if (pcm_l_vld_o) begin
        if (q_l.size() == 0) chk(0, "R7 unexpected left strobe", pcm_l_o, 0);
        else begin
          logic [16:0] e; e = q_l.pop_front();
          chk(pcm_l_o == e, "R7/R8 left sample", pcm_l_o, e);
        end
      end
      if (pcm_r_vld_o) begin
        if (q_r.size() == 0) chk(0, "R7 unexpected right strobe", pcm_r_o, 0);
        else begin
          logic [16:0] e; e = q_r.pop_front();
          chk(pcm_r_o == e, "R7/R8 right sample", pcm_r_o, e);
        end
      end
      if (rd_req_o) begin
        if (q_rd.size() == 0) chk(0, "R6 unexpected read request", rd_idx_o, 0);
        else begin
          logic [22:0] e; e = q_rd.pop_front();
          chk({rd_idx_o, rd_data_o} == e, "R6/R5 read result", {rd_idx_o, rd_data_o}, e);
        end
      end
    end
  end

  task automatic cyc(input bit en, input bit sy, input bit d);
    @(negedge clk);
    smp_en = en; sync_i = sy; sdo_i = d;
  endtask

  // drive a frame; expectations are pushed from the requirements
  task automatic frame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4,
                       input bit gaps, input int nbits);
    logic [95:0] bits;
    bits = {tag, s1, s2, s3, s4};
    if (nbits == 96 && tag[15]) begin
      if (tag[14]) begin
        if (s1[19]) begin
          logic [6:0] ix; ix = s1[18:12];
          q_rd.push_back({ix, ix[0] ? 16'h0 : mdl[ix[6:1]]});
        end else if (tag[13] && !s1[12]) begin
          mdl[s1[18:13]] = s2[19:4];
        end
      end
      if (tag[12]) q_l.push_back(rnd17(s3));
      if (tag[11]) q_r.push_back(rnd17(s4));
    end
    cyc(1, 1, 0);
    for (int i = 0; i < nbits; i++) begin
      logic b; b = bits[95-i];
      if (gaps && (i % 7 == 3)) cyc(0, ~(i < 15), ~b);
      cyc(1, i < 15, b);
    end
    if (nbits == 96) repeat (6) cyc(1, 0, 0);
  endtask

  function automatic logic [19:0] wcmd(input logic [6:0] ix);
    return {1'b0, ix, 12'h0};
  endfunction
  function automatic logic [19:0] rcmd(input logic [6:0] ix);
    return {1'b1, ix, 12'h0};
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(pcm_l_o == 0 && pcm_r_o == 0, "R10 pcm reset", {pcm_l_o, pcm_r_o}, 0);
    chk(!pcm_l_vld_o && !pcm_r_vld_o && !rd_req_o, "R10 strobes reset", {pcm_l_vld_o, pcm_r_vld_o, rd_req_o}, 0);
    chk(pwr_ctl_o == 0, "R10 pwr reset", pwr_ctl_o, 0);
    repeat (2) cyc(1, 0, 0);
    frame(16'hE000, rcmd(7'h10), 0, 0, 0, 0, 96);           // R10 register reads 0

    // R4 write and read back
    frame(16'hE000, wcmd(7'h02), 20'hA5C30, 0, 0, 0, 96);
    frame(16'hC000, rcmd(7'h02), 0, 0, 0, 0, 96);
    // R4 slot-2 tag clear: no write
    begin
      logic [19:0] s1; s1 = wcmd(7'h02);
      frame(16'hC000, s1, 20'h11110, 0, 0, 0, 96);
    end
    frame(16'hC000, rcmd(7'h02), 0, 0, 0, 0, 96);
    // R5 odd write ignored, odd read returns 0
    frame(16'hE000, wcmd(7'h03), 20'hFFFF0, 0, 0, 0, 96);
    frame(16'hC000, rcmd(7'h03), 0, 0, 0, 0, 96);
    frame(16'hC000, rcmd(7'h02), 0, 0, 0, 0, 96);
    // R3 frame-valid clear: nothing happens (monitor flags any strobe)
    q_l.push_back(17'h0); q_l.pop_back();
    cyc(1, 1, 0); // placeholder cycle kept low-impact: restart follows
    repeat (2) cyc(1, 0, 0);
    begin
      logic [95:0] b; b = {16'h7FFF, wcmd(7'h02), 20'h12340, 20'h40000, 20'h40000};
      cyc(1, 1, 0);
      for (int i = 0; i < 96; i++) cyc(1, i < 15, b[95-i]);
      repeat (6) cyc(1, 0, 0);
    end
    frame(16'hC000, rcmd(7'h02), 0, 0, 0, 0, 96);
    // R7 R8 samples and rounding corners
    frame(16'h9800, 0, 0, 20'h12345, 20'hFFFFB, 0, 96);
    frame(16'h9800, 0, 0, 20'h7FFFF, 20'h80000, 0, 96);   // R8 saturation, most negative
    frame(16'h9800, 0, 0, 20'h7FFFB, 20'hFFFFC, 0, 96);
    frame(16'h9000, 0, 0, 20'h00004, 20'h55555, 0, 96);   // R7 only left
    frame(16'h8800, 0, 0, 20'h33333, 20'h0000C, 0, 96);   // R7 only right
    // R9 powerdown register
    frame(16'hE000, wcmd(7'h26), 20'hFFEA0, 0, 0, 0, 96);
    chk(pwr_ctl_o == 6'h2A, "R9 pwr bits", pwr_ctl_o, 6'h2A);
    frame(16'hE000, wcmd(7'h24), 20'h00000, 0, 0, 0, 96);
    chk(pwr_ctl_o == 6'h2A, "R9 pwr unaffected by other index", pwr_ctl_o, 6'h2A);
    // R11 low tag bits ignored
    frame(16'hE7FF, wcmd(7'h04), 20'hBEEF0, 0, 0, 0, 96);
    frame(16'hDFFF, rcmd(7'h04), 0, 20'h77770, 20'h00008, 20'h00010, 96);
    // R2 gaps with inverted data on idle cycles
    frame(16'hF800, wcmd(7'h06), 20'h5A5A0, 20'h2468A, 20'hFFF00, 1, 96);
    frame(16'hC000, rcmd(7'h06), 0, 0, 0, 1, 96);
    // R1 aborted frame then restart
    frame(16'hF800, wcmd(7'h08), 20'hDEAD0, 20'h11111, 20'h22222, 0, 40);
    frame(16'hF800, wcmd(7'h0A), 20'hCAFE0, 20'h01000, 20'h02000, 0, 96);
    frame(16'hC000, rcmd(7'h08), 0, 0, 0, 0, 96);
    frame(16'hC000, rcmd(7'h0A), 0, 0, 0, 0, 96);
    // R12 top index
    frame(16'hE000, wcmd(7'h7E), 20'h13570, 0, 0, 0, 96);
    frame(16'hC000, rcmd(7'h7E), 0, 0, 0, 0, 96);
    chk(pwr_ctl_o == 6'h2A, "R9 pwr kept", pwr_ctl_o, 6'h2A);

    repeat (4) cyc(1, 0, 0);
    chk(q_l.size() == 0, "R7 left queue drained", q_l.size(), 0);
    chk(q_r.size() == 0, "R7 right queue drained", q_r.size(), 0);
    chk(q_rd.size() == 0, "R6 read queue drained", q_rd.size(), 0);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule